// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns three digitised Hall sensor levels into the six gate enables of a three-phase bridge, one high-side and one low-side enable per phase. Each Hall code in the motoring sequence gives one phase a high-side connection and another phase a low-side connection. The third phase is left floating. Drive strength comes from an external PWM gate. Only the low-side enable is chopped by that gate, and the high-side enable of a conducting phase stays on for its whole interval.

A start/stop input selects between running and braking. While braking, a brake-select input chooses how: free-run opens all switches, and reverse torque swaps each phase's high and low assignments relative to the motoring table. A disable input from the protection logic removes all low-side drive at once. All six enables leave the block through flops, so the bridge sees glitch-free levels one clock after the inputs settle.

Top module: `hall_commutator`

## Requirements
- R1: While rst_ni is low, all six enables are 0.
- R2: With hall_i[0] as sensor 1, hall_i[1] as sensor 2 and hall_i[2] as sensor 3, and run mode selected, the six legal codes give these phase assignments (H = high side, L = low side, - = off, phases 1/2/3 on bit 0/1/2 of each output): s1s2s3=101 gives L,H,-; 100 gives L,-,H; 110 gives -,L,H; 010 gives H,L,-; 011 gives H,-,L; 001 gives -,H,L.
- R3: Hall codes with all sensors low or all sensors high give all six enables 0 in every mode.
- R4: A phase's low-side enable is asserted only while pwm_i is 1; the high-side enables do not depend on pwm_i.
- R5: stop_i = 0 selects run mode; stop_i = 1 selects braking.
- R6: In braking with brake_free_i = 1, all six enables are 0.
- R7: In braking with brake_free_i = 0, each phase driven high by the motoring table is driven low instead and each phase driven low is driven high; the floating phase stays off.
- R8: disable_i = 1 forces all three low-side enables to 0 and leaves the high-side enables as they would otherwise be.
- R9: No phase ever has its high-side and low-side enables asserted together.
- R10: Every enable reflects the inputs sampled at the previous rising clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Hall levels, bit n = sensor n+1 |
| pwm_i | input | 1 | PWM gate for the low-side switches |
| stop_i | input | 1 | 1 = brake, 0 = run |
| brake_free_i | input | 1 | 1 = free-run braking, 0 = reverse torque |
| disable_i | input | 1 | Forces low-side enables off |
| hs_en_o | output | 3 | High-side enables, bit n = phase n+1 |
| ls_en_o | output | 3 | Low-side enables, bit n = phase n+1 |

## Verification
The bench sweeps every combination of Hall code, PWM level, run/brake, brake style and disable, so each commutation step is seen with the gate both open and closed. A mistake in the table, such as a swapped sector or a wrong bit order, shows up as a wrong phase conducting. A design that chops the high side would drop high-side drive when the gate is low. Reverse braking with the roles left unswapped would keep motoring instead of braking, and a disable that also clears the high side would fail the check that high-side drive is kept. Each vector is also sampled just before its clock edge, which catches outputs that are not registered.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;
  localparam int unsigned PHASES = 3;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_COAST   = 2'd1,
    MODE_REVERSE = 2'd2
  } drive_mode_e;
endpackage

// File: rtl/hall_sector_decode.sv
module hall_sector_decode
  import hall_comm_pkg::*;
(
  input  logic [PHASES-1:0] hall_i,
  output logic [PHASES-1:0] hi_o,
  output logic [PHASES-1:0] lo_o
);
  // bit n of hall_i is sensor n+1; bit n of hi_o/lo_o is phase n+1
  always_comb begin
    hi_o = '0;
    lo_o = '0;
    unique case (hall_i)
      3'b101: begin hi_o = 3'b010; lo_o = 3'b001; end
      3'b001: begin hi_o = 3'b100; lo_o = 3'b001; end
      3'b011: begin hi_o = 3'b100; lo_o = 3'b010; end
      3'b010: begin hi_o = 3'b001; lo_o = 3'b010; end
      3'b110: begin hi_o = 3'b001; lo_o = 3'b100; end
      3'b100: begin hi_o = 3'b010; lo_o = 3'b100; end
      default: begin hi_o = '0; lo_o = '0; end
    endcase
  end
endmodule

// File: rtl/drive_mode_select.sv
module drive_mode_select
  import hall_comm_pkg::*;
(
  input  logic        stop_i,
  input  logic        brake_free_i,
  output drive_mode_e mode_o
);
  always_comb begin
    if (!stop_i)           mode_o = MODE_RUN;
    else if (brake_free_i) mode_o = MODE_COAST;
    else                   mode_o = MODE_REVERSE;
  end
endmodule

// File: rtl/phase_gate.sv
module phase_gate
  import hall_comm_pkg::*;
(
  input  logic        hi_i,
  input  logic        lo_i,
  input  drive_mode_e mode_i,
  input  logic        pwm_i,
  input  logic        disable_i,
  output logic        hs_o,
  output logic        ls_o
);
  logic hs_sel, ls_sel;

  always_comb begin
    unique case (mode_i)
      MODE_RUN:     begin hs_sel = hi_i; ls_sel = lo_i; end
      MODE_REVERSE: begin hs_sel = lo_i; ls_sel = hi_i; end
      default:      begin hs_sel = 1'b0; ls_sel = 1'b0; end
    endcase
  end

  // chop only the low side; high side conducts for the full interval
  assign hs_o = hs_sel;
  assign ls_o = ls_sel & pwm_i & ~disable_i;
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_comm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PHASES-1:0] hall_i,
  input  logic              pwm_i,
  input  logic              stop_i,
  input  logic              brake_free_i,
  input  logic              disable_i,
  output logic [PHASES-1:0] hs_en_o,
  output logic [PHASES-1:0] ls_en_o
);
  logic [PHASES-1:0] hi_asg, lo_asg;
  logic [PHASES-1:0] hs_next, ls_next;
  drive_mode_e       mode;

  hall_sector_decode u_decode (
    .hall_i (hall_i),
    .hi_o   (hi_asg),
    .lo_o   (lo_asg)
  );

  drive_mode_select u_mode (
    .stop_i       (stop_i),
    .brake_free_i (brake_free_i),
    .mode_o       (mode)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    phase_gate u_gate (
      .hi_i      (hi_asg[g]),
      .lo_i      (lo_asg[g]),
      .mode_i    (mode),
      .pwm_i     (pwm_i),
      .disable_i (disable_i),
      .hs_o      (hs_next[g]),
      .ls_o      (ls_next[g])
    );

    p_no_shoot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_en_o[g] && ls_en_o[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_en_o <= '0;
      ls_en_o <= '0;
    end else begin
      hs_en_o <= hs_next;
      ls_en_o <= ls_next;
    end
  end

  p_illegal_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hall_i == 3'b000 || hall_i == 3'b111) |=> (hs_en_o == '0 && ls_en_o == '0));

  p_pwm_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> (ls_en_o == '0));

  p_free_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && brake_free_i) |=> (hs_en_o == '0 && ls_en_o == '0));

  p_dis_ls_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (ls_en_o == '0));

  p_one_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hs_en_o) && $onehot0(ls_en_o));
endmodule

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] hall_i = 3'b000;
  logic       pwm_i = 1'b0;
  logic       stop_i = 1'b1;
  logic       brake_free_i = 1'b1;
  logic       disable_i = 1'b0;
  logic [2:0] hs_en_o, ls_en_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  hall_commutator dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hall_i(hall_i), .pwm_i(pwm_i),
    .stop_i(stop_i), .brake_free_i(brake_free_i), .disable_i(disable_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );

  // motoring assignment from sensors s1,s2,s3 (R2, R3)
  function automatic void motor_asg(input logic [2:0] h,
                                    output logic [2:0] hi, output logic [2:0] lo);
    logic s1, s2, s3;
    s1 = h[0]; s2 = h[1]; s3 = h[2];
    hi = '0; lo = '0;
    case ({s1, s2, s3})
      3'b101: begin lo[0] = 1; hi[1] = 1; end
      3'b100: begin lo[0] = 1; hi[2] = 1; end
      3'b110: begin lo[1] = 1; hi[2] = 1; end
      3'b010: begin hi[0] = 1; lo[1] = 1; end
      3'b011: begin hi[0] = 1; lo[2] = 1; end
      3'b001: begin hi[1] = 1; lo[2] = 1; end
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s hall=%b pwm=%b stop=%b free=%b dis=%b act={hs,ls}=%b exp=%b",
               req, hall_i, pwm_i, stop_i, brake_free_i, disable_i, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] prev_exp;
    repeat (3) @(negedge clk_i);
    check("R1 reset", {hs_en_o, ls_en_o}, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    prev_exp = 6'b0;
    for (int v = 0; v < 128; v++) begin
      logic [2:0] hi, lo, ehs, els;
      logic [5:0] e;
      string tag;
      hall_i       = v[2:0];
      pwm_i        = v[3];
      stop_i       = v[4];
      brake_free_i = v[5];
      disable_i    = v[6];
      motor_asg(hall_i, hi, lo);
      if (!stop_i) begin
        ehs = hi; els = lo;                    // R5 run
      end else if (brake_free_i) begin
        ehs = '0; els = '0;                    // R6 free-run
      end else begin
        ehs = lo; els = hi;                    // R7 reverse torque
      end
      els = pwm_i ? els : 3'b000;              // R4
      if (disable_i) els = 3'b000;             // R8
      e = {ehs, els};
      // R10: before the edge the previous result must still be held
      #5;
      check("R10 held before edge", {hs_en_o, ls_en_o}, prev_exp);
      @(negedge clk_i);
      if (hall_i == 3'b000 || hall_i == 3'b111) tag = "R3 illegal code";
      else if (disable_i)    tag = "R8 disable";
      else if (!pwm_i)       tag = "R4 pwm low";
      else if (!stop_i)      tag = "R2 R5 motoring";
      else if (brake_free_i) tag = "R6 free-run";
      else                   tag = "R7 reverse";
      check(tag, {hs_en_o, ls_en_o}, e);
      checks++;
      if ((hs_en_o & ls_en_o) != 3'b000) begin
        errors++;
        $display("FAIL R9 overlap act hs=%b ls=%b exp no common bit", hs_en_o, ls_en_o);
      end
      prev_exp = e;
    end
    rst_ni = 1'b0;
    #3;
    check("R1 async reset", {hs_en_o, ls_en_o}, 6'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule